// File: doc/BRIEF.md
# NAND Flash Register Bridge with Half-Page ECC

This block sits between a byte-wide host register bus and a raw 8-bit NAND flash device. Host software drives the flash command, address and enable pins one bit at a time by writing a control register. Every host write to the data register becomes exactly one timed write strobe on the flash I/O bus. Every host read of the data register becomes exactly one timed read strobe, and the sampled byte is returned to the host.

Alongside the data port, an error-code accumulator folds each written byte into a Hamming-style code. It keeps row parity pairs indexed by the byte's position in the chunk, column parity pairs indexed by the bit's position in the byte, and a byte counter that wraps at the chunk size, 256 by default. After a chunk, software reads the parity registers, stores their inverse in the spare area, and expects the counter to read zero. Any write to the clear register restarts the accumulator, so a 512-byte page takes two clear, accumulate and read rounds. Flash reads leave the accumulator untouched.

The host request channel is valid/ready. A request moves when `host_valid` and `host_ready` are both high on a clock edge. Once the host raises `host_valid`, it must hold address, direction and data stable until that edge. `host_ready` is low for the whole of a flash strobe, including its hold cycle, and during the cycle in which a register read answer is presented. The answer channel has no back-pressure: `rsp_valid` is a single-cycle pulse that the host must take when it appears. Writes produce no answer.

Top module: `nand_bridge`

## Requirements
- R1: After reset, both chip-enable pins are high, write-protect is low (protected), CLE and ALE are low, both strobes are high, the bus is not driven, the parity registers and the counter read 0, and the control register reads 0x11 with the busy pin low.
- R2: A write to the control register (offset 0x18) sets the pins from its bits: bit0 is chip enable 0 (active low), bit1 is CLE, bit2 is ALE, bit3 is write-protect (active low) and bit4 is chip enable 1 (active low). Reading the register back returns those five bits.
- R3: Control bit5 reads the current ready/busy pin level. Write data in bits 5 to 7 is ignored, and bits 7 to 6 read as 0.
- R4: A host write to the data register (offset 0x14) produces exactly one write strobe, low for STROBE_CYCLES clock cycles. The byte is driven, with output enable high, throughout the low phase and at the rising edge of the strobe.
- R5: A host read of the data register produces exactly one read strobe, low for STROBE_CYCLES cycles. It returns the bus byte sampled in the last low cycle. It changes neither the parity registers nor the counter.
- R6: `host_ready` is low from the cycle after a flash access is accepted until the strobe and its one hold cycle have ended. A request presented meanwhile has no effect.
- R7: Row parity is 16 bits. Bit 2k is the XOR of the parities of all bytes whose chunk index has bit k clear, and bit 2k+1 covers the bytes whose index has bit k set. Offset 0x00 returns bits 7 to 0 and offset 0x04 returns bits 15 to 8.
- R8: Column parity is 6 bits. Bit 2k is the XOR of all data bits whose bit position has bit k clear, and bit 2k+1 covers the positions with bit k set. Offset 0x08 returns it in bits 5 to 0, with bits 7 to 6 read as 0.
- R9: Offset 0x0C returns the number of data bytes written since the last clear, modulo 256. It reads 0 after exactly a full chunk. The parity registers keep accumulating across the wrap.
- R10: A write of any value to offset 0x10 zeroes the row parity, the column parity and the counter.
- R11: Reads of offset 0x10, of unaligned offsets and of unlisted offsets return 0. Writes to the parity and counter registers, to unaligned offsets and to unlisted offsets change nothing.
- R12: Every accepted read produces exactly one `rsp_valid` pulse, and accepted writes produce none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_valid | input | 1 | Host request valid |
| host_ready | output | 1 | Bridge can accept a request |
| host_write | input | 1 | 1 = write, 0 = read |
| host_addr | input | 5 | Byte offset of the register |
| host_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | One-cycle read answer strobe |
| rsp_data | output | 8 | Read answer data |
| nand_io_out | output | 8 | Byte driven toward the flash |
| nand_io_oe | output | 1 | Output enable for nand_io_out |
| nand_io_in | input | 8 | Byte from the flash bus |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_ce_n | output | 2 | Chip enables, active low (bit1 = device 1) |
| nand_wp_n | output | 1 | Write protect, active low |
| nand_rb | input | 1 | Ready/busy pin from the flash |

## Verification
The hardest state to reach from the ports is a counter that has wrapped past a full chunk while the parity registers still carry bytes from before the wrap. Only a long run of data writes with no clear gets there. The bench writes a partial chunk followed by enough bytes to cross 256 and compares the registers with its own model. It also writes all-ones and single-bit chunks, which give known parity patterns. A request held against a low `host_ready` is another case that ordinary traffic never produces. The bench holds a control write pending across a whole strobe and then withdraws it, and checks that the pins did not move.

// File: rtl/nandb_pkg.sv
package nandb_pkg;

  localparam int REG_AW = 5;

  // register offsets (host byte addresses)
  localparam logic [REG_AW-1:0] OFS_ROW_LO = 5'h00;
  localparam logic [REG_AW-1:0] OFS_ROW_HI = 5'h04;
  localparam logic [REG_AW-1:0] OFS_COL    = 5'h08;
  localparam logic [REG_AW-1:0] OFS_COUNT  = 5'h0C;
  localparam logic [REG_AW-1:0] OFS_CLEAR  = 5'h10;
  localparam logic [REG_AW-1:0] OFS_DATA   = 5'h14;
  localparam logic [REG_AW-1:0] OFS_CTRL   = 5'h18;

  // control register layout
  localparam int CTL_W = 5;
  localparam int CTL_CE0_N = 0;
  localparam int CTL_CLE   = 1;
  localparam int CTL_ALE   = 2;
  localparam int CTL_WP_N  = 3;
  localparam int CTL_CE1_N = 4;
  localparam logic [CTL_W-1:0] CTL_RESET = 5'b10001;

  localparam int COL_W = 6;

  typedef enum logic [1:0] {PH_IDLE, PH_LOW, PH_HOLD} phase_t;

  // mask of bit positions within a byte whose index bit k equals sel
  function automatic logic [7:0] col_mask(input int k, input logic sel);
    logic [7:0] m;
    for (int b = 0; b < 8; b++) m[b] = (((b >> k) & 1) == int'(sel));
    return m;
  endfunction

endpackage

// File: rtl/nandb_ecc.sv
module nandb_ecc
  import nandb_pkg::*;
#(
  parameter int CHUNK_BYTES = 256
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                clr,
  input  logic                                fold,
  input  logic [7:0]                          din,
  output logic [2*$clog2(CHUNK_BYTES)-1:0]    row_par,
  output logic [COL_W-1:0]                    col_par,
  output logic [$clog2(CHUNK_BYTES)-1:0]      count
);
  localparam int IDX_W = $clog2(CHUNK_BYTES);
  localparam int ROW_W = 2 * IDX_W;

  logic             byte_par;
  logic [ROW_W-1:0] row_hit;
  logic [COL_W-1:0] col_hit;

  assign byte_par = ^din;

  // row pairs: one pair per chunk-index bit
  for (genvar k = 0; k < IDX_W; k++) begin : g_row
    assign row_hit[2*k]   = byte_par & ~count[k];
    assign row_hit[2*k+1] = byte_par &  count[k];
  end

  // column pairs: one pair per bit-position bit
  for (genvar k = 0; k < COL_W/2; k++) begin : g_col
    assign col_hit[2*k]   = ^(din & col_mask(k, 1'b0));
    assign col_hit[2*k+1] = ^(din & col_mask(k, 1'b1));
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      row_par <= '0;
      col_par <= '0;
      count   <= '0;
    end else if (fold) begin
      row_par <= row_par ^ row_hit;
      col_par <= col_par ^ col_hit;
      count   <= count + 1'b1;
    end
  end

endmodule

// File: rtl/nandb_pins.sv
module nandb_pins
  import nandb_pkg::*;
#(
  parameter int STROBE_CYCLES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_wr,
  input  logic       start_rd,
  input  logic [7:0] wdata,
  input  logic [7:0] io_in,
  output logic       we_n,
  output logic       re_n,
  output logic [7:0] io_out,
  output logic       io_oe,
  output logic       busy,
  output logic       rd_done,
  output logic [7:0] rd_data
);
  localparam int CW = (STROBE_CYCLES > 1) ? $clog2(STROBE_CYCLES) : 1;

  phase_t        phase;
  logic          is_wr;
  logic [CW-1:0] left;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase   <= PH_IDLE;
      is_wr   <= 1'b0;
      left    <= '0;
      io_out  <= '0;
      rd_data <= '0;
      rd_done <= 1'b0;
    end else begin
      rd_done <= 1'b0;
      case (phase)
        PH_IDLE: begin
          if (start_wr || start_rd) begin
            phase <= PH_LOW;
            is_wr <= start_wr;
            left  <= CW'(STROBE_CYCLES - 1);
            if (start_wr) io_out <= wdata;
          end
        end
        PH_LOW: begin
          if (left == '0) begin
            phase <= PH_HOLD;
            if (!is_wr) begin
              rd_data <= io_in;
              rd_done <= 1'b1;
            end
          end else begin
            left <= left - 1'b1;
          end
        end
        PH_HOLD: phase <= PH_IDLE;
        default: phase <= PH_IDLE;
      endcase
    end
  end

  assign we_n  = !((phase == PH_LOW) && is_wr);
  assign re_n  = !((phase == PH_LOW) && !is_wr);
  assign io_oe = is_wr && (phase != PH_IDLE);
  assign busy  = (phase != PH_IDLE);

endmodule

// File: rtl/nandb_ctl.sv
module nandb_ctl
  import nandb_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [CTL_W-1:0] wdata,
  output logic [CTL_W-1:0] ctl
);
  always_ff @(posedge clk) begin
    if (!rst_n)  ctl <= CTL_RESET;
    else if (wr) ctl <= wdata;
  end
endmodule

// File: rtl/nand_bridge.sv
module nand_bridge
  import nandb_pkg::*;
#(
  parameter int STROBE_CYCLES = 2,
  parameter int CHUNK_BYTES   = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_valid,
  output logic              host_ready,
  input  logic              host_write,
  input  logic [REG_AW-1:0] host_addr,
  input  logic [7:0]        host_wdata,
  output logic              rsp_valid,
  output logic [7:0]        rsp_data,
  output logic [7:0]        nand_io_out,
  output logic              nand_io_oe,
  input  logic [7:0]        nand_io_in,
  output logic              nand_we_n,
  output logic              nand_re_n,
  output logic              nand_cle,
  output logic              nand_ale,
  output logic [1:0]        nand_ce_n,
  output logic              nand_wp_n,
  input  logic              nand_rb
);
  localparam int IDX_W = $clog2(CHUNK_BYTES);
  localparam int ROW_W = 2 * IDX_W;

  logic             accept, busy, rd_done;
  logic             data_wr, data_rd, ctl_wr, ecc_clr, reg_rd;
  logic [7:0]       rd_byte;
  logic [ROW_W-1:0] row_par;
  logic [COL_W-1:0] col_par;
  logic [IDX_W-1:0] ecc_count;
  logic [15:0]      row16;
  logic [7:0]       cnt8;
  logic [CTL_W-1:0] ctl;
  logic             reg_rsp_q;
  logic [7:0]       reg_rdata_q, reg_mux;

  assign host_ready = !busy && !reg_rsp_q;
  assign accept     = host_valid && host_ready;

  assign data_wr = accept &&  host_write && (host_addr == OFS_DATA);
  assign data_rd = accept && !host_write && (host_addr == OFS_DATA);
  assign ctl_wr  = accept &&  host_write && (host_addr == OFS_CTRL);
  assign ecc_clr = accept &&  host_write && (host_addr == OFS_CLEAR);
  assign reg_rd  = accept && !host_write && (host_addr != OFS_DATA);

  nandb_ctl u_ctl (
    .clk   (clk),
    .rst_n (rst_n),
    .wr    (ctl_wr),
    .wdata (host_wdata[CTL_W-1:0]),
    .ctl   (ctl)
  );

  nandb_ecc #(.CHUNK_BYTES(CHUNK_BYTES)) u_ecc (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (ecc_clr),
    .fold    (data_wr),
    .din     (host_wdata),
    .row_par (row_par),
    .col_par (col_par),
    .count   (ecc_count)
  );

  nandb_pins #(.STROBE_CYCLES(STROBE_CYCLES)) u_pins (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_wr (data_wr),
    .start_rd (data_rd),
    .wdata    (host_wdata),
    .io_in    (nand_io_in),
    .we_n     (nand_we_n),
    .re_n     (nand_re_n),
    .io_out   (nand_io_out),
    .io_oe    (nand_io_oe),
    .busy     (busy),
    .rd_done  (rd_done),
    .rd_data  (rd_byte)
  );

  assign row16 = 16'(row_par);
  assign cnt8  = 8'(ecc_count);

  always_comb begin
    case (host_addr)
      OFS_ROW_LO: reg_mux = row16[7:0];
      OFS_ROW_HI: reg_mux = row16[15:8];
      OFS_COL:    reg_mux = {2'b00, col_par};
      OFS_COUNT:  reg_mux = cnt8;
      OFS_CTRL:   reg_mux = {2'b00, nand_rb, ctl};
      default:    reg_mux = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reg_rsp_q   <= 1'b0;
      reg_rdata_q <= 8'h00;
    end else begin
      reg_rsp_q <= reg_rd;
      if (reg_rd) reg_rdata_q <= reg_mux;
    end
  end

  assign rsp_valid = reg_rsp_q | rd_done;
  assign rsp_data  = rd_done ? rd_byte : reg_rdata_q;

  assign nand_ce_n = {ctl[CTL_CE1_N], ctl[CTL_CE0_N]};
  assign nand_cle  = ctl[CTL_CLE];
  assign nand_ale  = ctl[CTL_ALE];
  assign nand_wp_n = ctl[CTL_WP_N];

endmodule

// File: rtl/nandb_chk.sv
module nandb_chk
  import nandb_pkg::*;
#(
  parameter int CHUNK_BYTES = 256
) (
  input logic              clk,
  input logic              rst_n,
  input logic              host_valid,
  input logic              host_ready,
  input logic              host_write,
  input logic [REG_AW-1:0] host_addr,
  input logic              rsp_valid,
  input logic              we_n,
  input logic              re_n,
  input logic              io_oe,
  input logic              cle,
  input logic              ale,
  input logic [1:0]        ce_n,
  input logic              wp_n,
  input logic [7:0]        cnt,
  input logic [15:0]       row
);
  logic acc_dw, acc_dr, acc_clr;
  assign acc_dw  = host_valid && host_ready &&  host_write && (host_addr == OFS_DATA);
  assign acc_dr  = host_valid && host_ready && !host_write && (host_addr == OFS_DATA);
  assign acc_clr = host_valid && host_ready &&  host_write && (host_addr == OFS_CLEAR);

  a_r1_reset_pins: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (ce_n == 2'b11 && !wp_n && !cle && !ale && we_n && re_n && !io_oe
                      && cnt == 8'h00 && row == 16'h0000));

  a_r4_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(!we_n && !re_n));

  a_r4_driven: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> io_oe);

  a_r6_no_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (!we_n || !re_n) |-> !host_ready);

  a_r12_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  a_r9_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    acc_dw |=> (int'(cnt) == (int'($past(cnt)) + 1) % CHUNK_BYTES));

  a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
    acc_clr |=> (cnt == 8'h00 && row == 16'h0000));

  a_r5_read_keeps_ecc: assert property (@(posedge clk) disable iff (!rst_n)
    acc_dr |=> ($stable(cnt) && $stable(row)));

endmodule

bind nand_bridge nandb_chk #(.CHUNK_BYTES(CHUNK_BYTES)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .host_valid (host_valid),
  .host_ready (host_ready),
  .host_write (host_write),
  .host_addr  (host_addr),
  .rsp_valid  (rsp_valid),
  .we_n       (nand_we_n),
  .re_n       (nand_re_n),
  .io_oe      (nand_io_oe),
  .cle        (nand_cle),
  .ale        (nand_ale),
  .ce_n       (nand_ce_n),
  .wp_n       (nand_wp_n),
  .cnt        (cnt8),
  .row        (row16)
);

// File: tb/sim_nand_bridge.sv
module sim_nand_bridge;
  localparam int CLK_NS = 10;
  localparam int STROBE = 2;
  localparam int CHUNK  = 256;

  localparam logic [4:0] A_RLO = 5'h00, A_RHI = 5'h04, A_COL = 5'h08, A_CNT = 5'h0C,
                         A_CLR = 5'h10, A_DAT = 5'h14, A_CTL = 5'h18;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_valid = 1'b0, host_write = 1'b0;
  logic [4:0] host_addr = '0;
  logic [7:0] host_wdata = '0;
  logic host_ready, rsp_valid;
  logic [7:0] rsp_data, nand_io_out;
  logic nand_io_oe, nand_we_n, nand_re_n, nand_cle, nand_ale, nand_wp_n;
  logic [1:0] nand_ce_n;
  logic [7:0] nand_io_in = 8'h00;
  logic nand_rb = 1'b0;

  nand_bridge #(.STROBE_CYCLES(STROBE), .CHUNK_BYTES(CHUNK)) u0 (
    .clk(clk), .rst_n(rst_n), .host_valid(host_valid), .host_ready(host_ready),
    .host_write(host_write), .host_addr(host_addr), .host_wdata(host_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .nand_io_out(nand_io_out),
    .nand_io_oe(nand_io_oe), .nand_io_in(nand_io_in), .nand_we_n(nand_we_n),
    .nand_re_n(nand_re_n), .nand_cle(nand_cle), .nand_ale(nand_ale),
    .nand_ce_n(nand_ce_n), .nand_wp_n(nand_wp_n), .nand_rb(nand_rb)
  );

  always #(CLK_NS/2) clk = ~clk;

  int checks = 0, fails = 0;
  int we_pulses = 0, re_pulses = 0, we_low = 0, re_low = 0, rsp_pulses = 0, reads_issued = 0;
  int undriven_we = 0;
  logic [7:0] last_wr = '0;

  always @(posedge nand_we_n) if (rst_n) begin
    we_pulses++;
    last_wr = nand_io_out;
    if (!nand_io_oe) undriven_we++;
  end
  always @(posedge nand_re_n) if (rst_n) re_pulses++;
  always @(posedge clk) if (rst_n) begin
    if (!nand_we_n) we_low++;
    if (!nand_re_n) re_low++;
    if (rsp_valid) rsp_pulses++;
  end

  // reference model of the accumulator
  logic [15:0] m_row = '0;
  logic [5:0]  m_col = '0;
  int          m_n = 0;
  logic [4:0]  m_ctl = 5'b10001;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic model_fold(input logic [7:0] d);
    int ones = 0;
    for (int b = 0; b < 8; b++) ones += int'(d[b]);
    for (int j = 0; j < 16; j++)
      if (((m_n >> (j / 2)) & 1) == (j % 2)) m_row[j] = m_row[j] ^ ones[0];
    for (int j = 0; j < 6; j++)
      for (int b = 0; b < 8; b++)
        if (((b >> (j / 2)) & 1) == (j % 2)) m_col[j] = m_col[j] ^ d[b];
    m_n = (m_n + 1) % CHUNK;
  endtask

  task automatic bus_wr(input logic [4:0] a, input logic [7:0] d);
    while (!host_ready) @(negedge clk);
    host_valid = 1'b1; host_write = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_valid = 1'b0; host_write = 1'b0;
  endtask

  task automatic bus_rd(input logic [4:0] a, output logic [7:0] d);
    while (!host_ready) @(negedge clk);
    host_valid = 1'b1; host_write = 1'b0; host_addr = a;
    reads_issued++;
    @(negedge clk);
    host_valid = 1'b0;
    while (!rsp_valid) @(negedge clk);
    d = rsp_data;
    @(negedge clk);
  endtask

  task automatic wait_idle();
    while (!host_ready) @(negedge clk);
  endtask

  task automatic data_wr(input logic [7:0] d);
    bus_wr(A_DAT, d);
    model_fold(d);
  endtask

  task automatic ecc_clear();
    bus_wr(A_CLR, 8'($urandom));
    m_row = '0; m_col = '0; m_n = 0;
  endtask

  task automatic check_ecc(input string tag);
    logic [7:0] v;
    bus_rd(A_RLO, v); chk({tag, " R7 row lo"}, v, m_row[7:0]);
    bus_rd(A_RHI, v); chk({tag, " R7 row hi"}, v, m_row[15:8]);
    bus_rd(A_COL, v); chk({tag, " R8 col"}, v, {2'b00, m_col});
    bus_rd(A_CNT, v); chk({tag, " R9 count"}, v, 8'(m_n));
  endtask

  task automatic ctl_wr(input logic [7:0] d);
    bus_wr(A_CTL, d);
    m_ctl = d[4:0];
  endtask

  task automatic check_pins(input string tag);
    chk({tag, " ce_n"}, nand_ce_n, {m_ctl[4], m_ctl[0]});
    chk({tag, " cle"}, nand_cle, m_ctl[1]);
    chk({tag, " ale"}, nand_ale, m_ctl[2]);
    chk({tag, " wp_n"}, nand_wp_n, m_ctl[3]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] v;
    int p0, l0, r0;
    void'($urandom(32'h5eed_0042));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 ce_n", nand_ce_n, 2'b11);
    chk("R1 wp_n", nand_wp_n, 1'b0);
    chk("R1 cle/ale", {nand_cle, nand_ale}, 2'b00);
    chk("R1 strobes", {nand_we_n, nand_re_n}, 2'b11);
    chk("R1 oe", nand_io_oe, 1'b0);
    bus_rd(A_CTL, v); chk("R1 ctrl", v, 8'h11);
    check_ecc("R1");

    // R2 control bits to pins
    ctl_wr(8'h0E); check_pins("R2 a");
    bus_rd(A_CTL, v); chk("R2 readback", v, 8'h0E);
    ctl_wr(8'h11); check_pins("R2 b");

    // R3 busy bit and ignored upper bits
    ctl_wr(8'hEA); check_pins("R3 pins");
    bus_rd(A_CTL, v); chk("R3 rb low", v, 8'h0A);
    nand_rb = 1'b1;
    bus_rd(A_CTL, v); chk("R3 rb high", v, 8'h2A);
    nand_rb = 1'b0;

    // R4 one write strobe of STROBE cycles
    p0 = we_pulses; l0 = we_low; r0 = re_pulses;
    data_wr(8'hA5); wait_idle();
    chk("R4 pulses", we_pulses - p0, 1);
    chk("R4 low width", we_low - l0, STROBE);
    chk("R4 byte", last_wr, 8'hA5);
    chk("R4 no read strobe", re_pulses - r0, 0);
    chk("R4 driven", undriven_we, 0);

    // R6 back-pressure, and a request held while busy is ignored
    wait_idle();
    host_valid = 1'b1; host_write = 1'b1; host_addr = A_DAT; host_wdata = 8'h3C;
    @(negedge clk);
    model_fold(8'h3C);
    host_addr = A_CTL; host_wdata = 8'h04;
    l0 = 0;
    while (!host_ready) begin l0++; @(negedge clk); end
    host_valid = 1'b0; host_write = 1'b0;
    chk("R6 busy cycles", l0, STROBE + 1);
    @(negedge clk);
    check_pins("R6 held ignored");

    // R5 data read
    nand_io_in = 8'h96;
    p0 = re_pulses; l0 = re_low; r0 = we_pulses;
    bus_rd(A_DAT, v);
    chk("R5 data", v, 8'h96);
    wait_idle();
    chk("R5 pulses", re_pulses - p0, 1);
    chk("R5 low width", re_low - l0, STROBE);
    chk("R5 no write strobe", we_pulses - r0, 0);
    check_ecc("R5 unchanged");

    // R10 clear
    ecc_clear();
    check_ecc("R10");

    // R7 R8 single byte at index 0, then fill chunk randomly
    data_wr(8'h80); check_ecc("R7 single");
    for (int i = 1; i < CHUNK; i++) data_wr(8'($urandom));
    check_ecc("R9 full chunk");
    chk("R9 zero after chunk", m_n, 0);

    // all-ones chunk gives zero parity
    ecc_clear();
    for (int i = 0; i < CHUNK; i++) data_wr(8'hFF);
    check_ecc("R8 all ones");

    // partial chunk then wrap without clear
    ecc_clear();
    for (int i = 0; i < 100; i++) data_wr(8'($urandom));
    check_ecc("R9 partial");
    for (int i = 0; i < 200; i++) data_wr(8'($urandom));
    check_ecc("R9 wrapped");

    // R11 read-only, clear and undefined offsets
    bus_rd(A_CLR, v); chk("R11 clear reads 0", v, 8'h00);
    bus_rd(5'h1C, v); chk("R11 undefined", v, 8'h00);
    bus_rd(5'h15, v); chk("R11 unaligned", v, 8'h00);
    bus_rd(5'h19, v); chk("R11 unaligned ctrl", v, 8'h00);
    p0 = we_pulses;
    bus_wr(A_RLO, 8'hFF); bus_wr(A_RHI, 8'h5A); bus_wr(A_COL, 8'h3F);
    bus_wr(A_CNT, 8'h07); bus_wr(5'h1C, 8'h00); bus_wr(5'h16, 8'h00); bus_wr(5'h1A, 8'h00);
    check_ecc("R11 writes ignored");
    bus_rd(A_CTL, v); chk("R11 ctrl kept", v, {3'b000, m_ctl});
    chk("R11 no strobe", we_pulses - p0, 0);

    // random mixture
    for (int it = 0; it < 400; it++) begin
      int op;
      op = int'($urandom % 10);
      if (op < 5) data_wr(8'($urandom));
      else if (op == 5) begin
        nand_io_in = 8'($urandom);
        bus_rd(A_DAT, v); chk("R5 random read", v, nand_io_in);
      end else if (op == 6) begin
        ctl_wr(8'($urandom)); check_pins("R2 random");
        bus_rd(A_CTL, v); chk("R2 random readback", v, {2'b00, nand_rb, m_ctl});
      end else if (op == 7) begin
        if ($urandom % 4 == 0) ecc_clear();
        nand_rb = 1'($urandom);
      end else check_ecc("R7 random");
    end
    check_ecc("R9 final");
    wait_idle();
    @(negedge clk);

    // R12 one answer per read
    chk("R12 answers", rsp_pulses, reads_issued);
    chk("R4 driven final", undriven_we, 0);

    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule